// File: doc/BRIEF.md
# Load-Line Droop Setpoint Generator

This block computes the voltage target of a digitally controlled point-of-load regulator when a load line is used. A positive droop resistance makes the target fall as the measured load current rises. The block averages the incoming current samples over a short window, subtracts the resulting drop from the nominal voltage and derives four fast-response comparator levels from that reduced target. Two levels sit below the target for load steps and two sit above it for unload steps, so the fast-response window moves with the target.

Current samples arrive on their own strobe, several per switching period. The result registers load only on the switching-cycle strobe and hold their value between strobes. When the regulator shares current with other phases, a floor is placed on the droop resistance so that every phase keeps a usable load line.

Top module: `droop_setpoint_gen`

## Requirements
- R1: While reset is held, the setpoint and all four threshold outputs read zero.
- R2: On a cycle strobe the setpoint becomes nomMv − floor(iFilt × effective droop / 256). Voltages are in mV, current samples in units of 1/16 A and the droop code in units of 1/16 mV/A.
- R3: iFilt is the floor of the mean of the four most recent samples taken on iValid. The history reads zero after reset.
- R4: With a droop code of zero and sharing off, the setpoint equals nomMv for any current.
- R5: When the computed drop exceeds nomMv, the setpoint saturates at 0 and does not wrap.
- R6: With shareEn high, the effective droop is max(droopCoef, 16), that is at least 1 mV/A. With shareEn low it is droopCoef.
- R7: The inner offset is floor(setpoint × innerFrac / 512). The inner load level is setpoint minus that offset and the inner unload level is setpoint plus it, clamped to 0..65535.
- R8: The outer offset is the inner offset times 2, 3 or 4 for outerMul codes 0, 1 and 2 or 3 respectively. The outer levels are setpoint minus and plus that offset, clamped to 0..65535, so loadOuter ≤ loadInner ≤ setpoint ≤ unloadInner ≤ unloadOuter.
- R9: The outputs change only at a clock edge where cycStb is high and are held otherwise. That update uses the samples accepted before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nomMv | input | 16 | Nominal output voltage, mV |
| droopCoef | input | 8 | Load-line resistance, 1/16 mV/A per LSB |
| shareEn | input | 1 | Current-sharing mode; enforces the minimum droop |
| innerFrac | input | 6 | Inner threshold offset, 1/512 of target per LSB |
| outerMul | input | 2 | Outer multiplier select: 0→2, 1→3, 2/3→4 |
| iSample | input | 12 | Measured load current, 1/16 A per LSB |
| iValid | input | 1 | Accept iSample into the filter this cycle |
| cycStb | input | 1 | Switching-cycle strobe; loads the outputs |
| setpoint | output | 16 | Drooped target voltage, mV |
| loadOuter | output | 16 | Outer level below target, mV |
| loadInner | output | 16 | Inner level below target, mV |
| unloadInner | output | 16 | Inner level above target, mV |
| unloadOuter | output | 16 | Outer level above target, mV |

## Verification
The assertions assume that every input is at a defined value on each clock edge and that the programming inputs may change on any cycle, including cycles with a strobe. Under that assumption the ordering of the five levels and the ceiling at nominal must hold for any code. The stimulus changes the programming only between groups of cycles, with random strobes and samples inside each group. It also forces the extreme codes that reach both saturation limits: full current with maximum droop against a small nominal voltage, and maximum nominal with the widest threshold settings.

// File: rtl/droop_pkg.sv
package droop_pkg;
  typedef struct packed {
    logic       shiftEn;
    logic       updateEn;
    logic       useMinDroop;
    logic [2:0] multSel;
  } droop_ctrl_t;
endpackage

// File: rtl/droop_ctrl.sv
module droop_ctrl
  import droop_pkg::*;
(
  input  logic        iValid,
  input  logic        cycStb,
  input  logic        shareEn,
  input  logic [1:0]  outerMul,
  output droop_ctrl_t ctrl
);
  always_comb begin
    ctrl.shiftEn     = iValid;
    ctrl.updateEn    = cycStb;
    ctrl.useMinDroop = shareEn;
    case (outerMul)
      2'd0:    ctrl.multSel = 3'b001;
      2'd1:    ctrl.multSel = 3'b010;
      default: ctrl.multSel = 3'b100;
    endcase
  end
endmodule

// File: rtl/droop_datapath.sv
module droop_datapath
  import droop_pkg::*;
#(
  parameter int VW        = 16,
  parameter int DW        = 8,
  parameter int IW        = 12,
  parameter int FW        = 6,
  parameter int AVG_LOG2  = 2,
  parameter int DROOP_FRAC = 8,
  parameter int THR_SHIFT = 9,
  parameter int MIN_DROOP = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  droop_ctrl_t   ctrl,
  input  logic [VW-1:0] nomMv,
  input  logic [DW-1:0] droopCoef,
  input  logic [FW-1:0] innerFrac,
  input  logic [IW-1:0] iSample,
  output logic [VW-1:0] setpoint,
  output logic [VW-1:0] loadOuter,
  output logic [VW-1:0] loadInner,
  output logic [VW-1:0] unloadInner,
  output logic [VW-1:0] unloadOuter
);
  localparam int TAPS  = 1 << AVG_LOG2;
  localparam int SUMW  = IW + AVG_LOG2;
  localparam int PRODW = IW + DW;
  localparam int CW    = (PRODW > VW) ? PRODW : VW;
  localparam int IPW   = VW + FW;
  localparam int EW    = VW + FW + 4;
  localparam logic [EW-1:0] VMAX = EW'({VW{1'b1}});

  logic [IW-1:0] hist [TAPS];

  generate
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
      if (g == 0) begin : g_head
        always_ff @(posedge clk)
          if (!rstN)             hist[g] <= '0;
          else if (ctrl.shiftEn) hist[g] <= iSample;
      end else begin : g_body
        always_ff @(posedge clk)
          if (!rstN)             hist[g] <= '0;
          else if (ctrl.shiftEn) hist[g] <= hist[g-1];
      end
    end
  endgenerate

  logic [SUMW-1:0]  sumAcc;
  logic [IW-1:0]    iFilt;
  logic [DW-1:0]    effDroop;
  logic [PRODW-1:0] dropProd;
  logic [CW-1:0]    nomX, dropX, targetX;
  logic [VW-1:0]    target;
  logic [IPW-1:0]   innerProd, innerDelta;
  logic [2:0]       multVal;
  logic [EW-1:0]    tE, inE, outE, hiIn, hiOut;
  logic [VW-1:0]    nLoadOuter, nLoadInner, nUnloadInner, nUnloadOuter;

  always_comb begin
    sumAcc = '0;
    for (int k = 0; k < TAPS; k++) sumAcc = sumAcc + SUMW'(hist[k]);
    iFilt = sumAcc[SUMW-1:AVG_LOG2];

    effDroop = (ctrl.useMinDroop && (droopCoef < DW'(MIN_DROOP))) ? DW'(MIN_DROOP) : droopCoef;
    dropProd = PRODW'(iFilt) * PRODW'(effDroop);
    nomX     = CW'(nomMv);
    dropX    = CW'(dropProd >> DROOP_FRAC);
    targetX  = (nomX > dropX) ? (nomX - dropX) : '0;
    target   = targetX[VW-1:0];

    innerProd  = IPW'(target) * IPW'(innerFrac);
    innerDelta = innerProd >> THR_SHIFT;
    multVal    = ctrl.multSel[0] ? 3'd2 : (ctrl.multSel[1] ? 3'd3 : 3'd4);

    tE    = EW'(target);
    inE   = EW'(innerDelta);
    outE  = inE * EW'(multVal);
    hiIn  = tE + inE;
    hiOut = tE + outE;

    nLoadInner   = (tE > inE)  ? VW'(tE - inE)  : '0;
    nLoadOuter   = (tE > outE) ? VW'(tE - outE) : '0;
    nUnloadInner = (hiIn  > VMAX) ? {VW{1'b1}} : hiIn[VW-1:0];
    nUnloadOuter = (hiOut > VMAX) ? {VW{1'b1}} : hiOut[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setpoint    <= '0;
      loadOuter   <= '0;
      loadInner   <= '0;
      unloadInner <= '0;
      unloadOuter <= '0;
    end else if (ctrl.updateEn) begin
      setpoint    <= target;
      loadOuter   <= nLoadOuter;
      loadInner   <= nLoadInner;
      unloadInner <= nUnloadInner;
      unloadOuter <= nUnloadOuter;
    end
  end

  // R9: outputs hold when no cycle strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.updateEn |=> ($stable(setpoint) && $stable(loadOuter) && $stable(loadInner)
                        && $stable(unloadInner) && $stable(unloadOuter)));

  // R8: the five levels stay ordered
  p_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadOuter <= loadInner) && (loadInner <= setpoint) &&
    (setpoint <= unloadInner) && (unloadInner <= unloadOuter));

  // R2: the drooped target never exceeds nominal
  p_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.updateEn |=> (setpoint <= $past(nomMv)));

  // R4: zero droop outside sharing mode gives nominal
  p_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.updateEn && (droopCoef == '0) && !ctrl.useMinDroop) |=> (setpoint == $past(nomMv)));

  // R6: sharing mode always droops with enough filtered current
  p_share_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.updateEn && ctrl.useMinDroop && (iFilt >= IW'(16)) && (nomMv != '0))
      |=> (setpoint < $past(nomMv)));
endmodule

// File: rtl/droop_setpoint_gen.sv
module droop_setpoint_gen
  import droop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] nomMv,
  input  logic [7:0]  droopCoef,
  input  logic        shareEn,
  input  logic [5:0]  innerFrac,
  input  logic [1:0]  outerMul,
  input  logic [11:0] iSample,
  input  logic        iValid,
  input  logic        cycStb,
  output logic [15:0] setpoint,
  output logic [15:0] loadOuter,
  output logic [15:0] loadInner,
  output logic [15:0] unloadInner,
  output logic [15:0] unloadOuter
);
  droop_ctrl_t ctrl;

  droop_ctrl i_ctrl (
    .iValid   (iValid),
    .cycStb   (cycStb),
    .shareEn  (shareEn),
    .outerMul (outerMul),
    .ctrl     (ctrl)
  );

  droop_datapath #(
    .VW(16), .DW(8), .IW(12), .FW(6), .AVG_LOG2(2),
    .DROOP_FRAC(8), .THR_SHIFT(9), .MIN_DROOP(16)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .nomMv       (nomMv),
    .droopCoef   (droopCoef),
    .innerFrac   (innerFrac),
    .iSample     (iSample),
    .setpoint    (setpoint),
    .loadOuter   (loadOuter),
    .loadInner   (loadInner),
    .unloadInner (unloadInner),
    .unloadOuter (unloadOuter)
  );
endmodule

// File: tb/test_droop_setpoint_gen.sv
module test_droop_setpoint_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] nomMv = '0;
  logic [7:0]  droopCoef = '0;
  logic        shareEn = 1'b0;
  logic [5:0]  innerFrac = '0;
  logic [1:0]  outerMul = '0;
  logic [11:0] iSample = '0;
  logic        iValid = 1'b0;
  logic        cycStb = 1'b0;
  logic [15:0] setpoint, loadOuter, loadInner, unloadInner, unloadOuter;

  always #5 clk = ~clk;

  droop_setpoint_gen i_droop_setpoint_gen (
    .clk(clk), .rstN(rstN), .nomMv(nomMv), .droopCoef(droopCoef), .shareEn(shareEn),
    .innerFrac(innerFrac), .outerMul(outerMul), .iSample(iSample), .iValid(iValid),
    .cycStb(cycStb), .setpoint(setpoint), .loadOuter(loadOuter), .loadInner(loadInner),
    .unloadInner(unloadInner), .unloadOuter(unloadOuter)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int hist [4];
  int eSet, eLo, eLi, eUi, eUo;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int filtModel();
    return (hist[0] + hist[1] + hist[2] + hist[3]) / 4;
  endfunction

  task automatic computeExp();
    int ed, drop, inD, outD, m;
    ed   = (shareEn && droopCoef < 16) ? 16 : int'(droopCoef);
    drop = (filtModel() * ed) / 256;
    eSet = (int'(nomMv) > drop) ? int'(nomMv) - drop : 0;
    inD  = (eSet * int'(innerFrac)) / 512;
    m    = (outerMul == 0) ? 2 : (outerMul == 1) ? 3 : 4;
    outD = inD * m;
    eLi  = (eSet > inD)  ? eSet - inD  : 0;
    eLo  = (eSet > outD) ? eSet - outD : 0;
    eUi  = (eSet + inD  > 65535) ? 65535 : eSet + inD;
    eUo  = (eSet + outD > 65535) ? 65535 : eSet + outD;
  endtask

  function automatic string setTag();
    if (eSet == 0 && nomMv != 0) return "R5";
    if (droopCoef == 0 && !shareEn) return "R4";
    if (shareEn) return "R6";
    return "R2";
  endfunction

  task automatic step(input logic v, input logic c, input logic [11:0] s, input string tag);
    int pSet, pLo, pLi, pUi, pUo;
    string t;
    iValid = v; cycStb = c; iSample = s;
    pSet = setpoint; pLo = loadOuter; pLi = loadInner; pUi = unloadInner; pUo = unloadOuter;
    if (c) computeExp();
    @(posedge clk);
    if (v) begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = int'(s);
    end
    @(negedge clk);
    if (c) begin
      t = (tag != "") ? tag : setTag();
      chk(t, setpoint, eSet);
      chk("R7", loadInner, eLi);
      chk("R7", unloadInner, eUi);
      chk("R8", loadOuter, eLo);
      chk("R8", unloadOuter, eUo);
    end else begin
      chk("R9", setpoint, pSet);
      chk("R9", loadOuter, pLo);
      chk("R9", loadInner, pLi);
      chk("R9", unloadInner, pUi);
      chk("R9", unloadOuter, pUo);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    int dummy;
    for (int k = 0; k < 4; k++) hist[k] = 0;
    dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", setpoint, 0);
    chk("R1", loadOuter, 0);
    chk("R1", loadInner, 0);
    chk("R1", unloadInner, 0);
    chk("R1", unloadOuter, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: mean of four samples, 400 -> drop 100
    nomMv = 16'd1000; droopCoef = 8'd64; innerFrac = 6'd10; outerMul = 2'd0;
    step(1, 0, 12'd160, "");
    step(1, 0, 12'd320, "");
    step(1, 0, 12'd480, "");
    step(1, 0, 12'd640, "");
    step(0, 1, 12'd0, "R3");
    chk("R3", setpoint, 900);
    // R9: strobe and sample on same edge uses old history
    step(1, 1, 12'd4000, "R9");
    step(0, 1, 12'd0, "R3");

    // R4: zero droop, large current
    droopCoef = 8'd0;
    for (int k = 0; k < 4; k++) step(1, 0, 12'd4095, "");
    step(0, 1, 12'd0, "R4");
    chk("R4", setpoint, 1000);

    // R6: sharing forces minimum droop
    shareEn = 1'b1;
    step(0, 1, 12'd0, "R6");
    chk("R6", setpoint, 1000 - 255);
    shareEn = 1'b0;

    // R5: saturation at zero
    nomMv = 16'd100; droopCoef = 8'd255;
    step(0, 1, 12'd0, "R5");
    chk("R5", setpoint, 0);

    // R8: upper clamp with widest window
    nomMv = 16'hFFFF; droopCoef = 8'd0; innerFrac = 6'd63;
    for (int code = 0; code < 4; code++) begin
      outerMul = 2'(code);
      step(0, 1, 12'd0, "R8");
    end
    chk("R8", unloadOuter, 65535);

    // random phase
    for (int grp = 0; grp < 400; grp++) begin
      nomMv     = 16'($urandom_range(0, 65535));
      droopCoef = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 255));
      shareEn   = 1'($urandom_range(0, 1));
      innerFrac = 6'($urandom_range(0, 63));
      outerMul  = 2'($urandom_range(0, 3));
      for (int k = 0; k < 8; k++)
        step(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
             12'($urandom_range(0, 4095)), "");
    end

    done = 1;
    finishRun();
  end
endmodule